// File: doc/BRIEF.md
# Burst Transmit Enable Sequencer

This block produces the per-burst control strobes for an upstream burst transmitter. A burst is a fixed sequence of sections counted in bit clocks. It starts with leading guard time, then a preamble and the user data. When Reed-Solomon parity is appended, a parity section follows. A trailing guard time ends the burst. The sequencer counts bit-clock ticks against section lengths that are captured when the burst is accepted. From that count it drives the enables for the differential encoder, the Reed-Solomon encoder and the scrambler, a data-enable output, and a symbol strobe.

All logic runs on the master clock. The bit clock arrives as a one-master-clock `bit_tick` pulse. The start request and the configuration are sampled on a cycle where `bit_tick` is high. All outputs change at that same master-clock edge, so every control effect shows up one master-clock period after the sampling tick. Bit index k counts the ticks after the accepting tick, beginning at 0. The section boundaries are:

- G = `guard_len`, the leading guard.
- P = `pre_len`, the preamble.
- D = `data_len`, the user data.
- Q = 16·`par_words` when `par_on` is set, and 0 otherwise.
- H = `tail_len`, the trailing guard.
- N = G+P+D+Q+H, the burst length in bits.

Top module: `bts_seq`

## Requirements
- R1: While `rst` is high and after it is released, with no start accepted, `busy`, `dfe_on`, `rse_on`, `scr_on`, `dout_en` and `sym_strobe` are all 0.
- R2: A start is accepted at a clock edge where `bit_tick`=1, `start`=1 and `busy`=0. `busy` is then 1 from that edge until the edge of the tick with k = N, where it returns to 0. The burst sections run in the order leading guard, preamble, user data, parity, trailing guard.
- R3: `dfe_on` is 1 for bits G ≤ k < G+P+D, which covers the preamble and the user data. It is 0 in both guard times and in the parity section.
- R4: `rse_on` rises on the first user bit (k = G+P). It falls on the tick of the last user bit, so it is 1 for G+P ≤ k < G+P+D−1.
- R5: `scr_on` rises on the first user bit. It falls one bit after the last user bit, so it is 1 for G+P ≤ k < G+P+D.
- R6: With `par_on`=0, `dout_en` is 1 for G ≤ k < G+P+D.
- R7: With `par_on`=1, `dout_en` rises eight bits late at k = G+8. A parity section of Q = 16·`par_words` bits follows the user data, and `dout_en` stays 1 for k < G+P+D+Q. The burst end moves later by Q.
- R8: `dfe_on`, `rse_on`, `scr_on`, `dout_en` and `busy` change only at a clock edge where `bit_tick` was 1.
- R9: `sym_strobe` is a single-master-clock pulse after the tick of every bit k < N with k mod SYM_BITS = 0. SYM_BITS defaults to 2.
- R10: While `busy`=1, a start request and any change of the length or option inputs have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit clock |
| start | input | 1 | Burst start request, sampled on a tick |
| guard_len | input | LEN_W | Leading guard length in bits |
| pre_len | input | LEN_W | Preamble length in bits |
| data_len | input | LEN_W | User data length in bits |
| tail_len | input | LEN_W | Trailing guard length in bits |
| par_words | input | T_W | Parity capability T; 2T bytes appended |
| par_on | input | 1 | Append parity and delay data-enable by 8 bits |
| dfe_on | output | 1 | Differential encoder enable |
| rse_on | output | 1 | Reed-Solomon encoder enable |
| scr_on | output | 1 | Scrambler enable |
| dout_en | output | 1 | Data-enable output |
| sym_strobe | output | 1 | Symbol boundary pulse |
| busy | output | 1 | Burst in progress |

## Verification
Two events can fall on the same tick. The first case is the end of a burst meeting a start request: `start` is held high across the final tick (k = N). The start must be refused on that tick and accepted on the following one. The second case sets P = 8 with parity enabled, so the delayed `dout_en` rise at G+8 lands on the same bit as the `rse_on`/`scr_on` rise at G+P. All outputs must change together after that tick. A behavioural reference model in the bench judges every output on every clock.

// File: rtl/bts_pkg.sv
package bts_pkg;
  // Width of every bit-index quantity; must cover 4 lengths plus parity bits.
  parameter int CNT_W = 11;
  typedef logic [CNT_W-1:0] bcnt_t;

  // Burst boundaries, all in bit index k from the first counted tick.
  typedef struct packed {
    bcnt_t pre_s;   // preamble start (G)
    bcnt_t dat_s;   // user data start (G+P)
    bcnt_t dat_e;   // first bit after user data
    bcnt_t de_s;    // data-enable rise
    bcnt_t par_e;   // first bit after parity
    bcnt_t tot;     // burst length N
  } bnd_t;
endpackage

// File: rtl/bts_bound.sv
module bts_bound
  import bts_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int T_W    = 4,
  parameter int DE_DLY = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             busy,
  input  logic [LEN_W-1:0] guard_len,
  input  logic [LEN_W-1:0] pre_len,
  input  logic [LEN_W-1:0] data_len,
  input  logic [LEN_W-1:0] tail_len,
  input  logic [T_W-1:0]   par_words,
  input  logic             par_on,
  output bnd_t             bnd
);
  // 2T bytes of 8 bits = 16*T bits
  localparam int PAR_SH = 4;

  bcnt_t g, p, d, h, q;
  bnd_t  nxt;

  always_comb begin
    g = bcnt_t'(guard_len);
    p = bcnt_t'(pre_len);
    d = bcnt_t'(data_len);
    h = bcnt_t'(tail_len);
    q = par_on ? (bcnt_t'(par_words) << PAR_SH) : '0;
    nxt.pre_s = g;
    nxt.dat_s = g + p;
    nxt.dat_e = g + p + d;
    nxt.de_s  = par_on ? g + bcnt_t'(DE_DLY) : g;
    nxt.par_e = g + p + d + q;
    nxt.tot   = g + p + d + q + h;
  end

  always_ff @(posedge clk) begin
    if (rst)         bnd <= '0;
    else if (accept) bnd <= nxt;
  end

  // R10
  bnd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(bnd));
endmodule

// File: rtl/bts_cnt.sv
module bts_cnt
  import bts_pkg::*;
#(
  parameter int SYM_BITS = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_tick,
  input  logic  start,
  input  bcnt_t tot,
  output logic  busy,
  output bcnt_t k,
  output logic  accept,
  output logic  step,
  output logic  fin,
  output logic  sym_zero
);
  localparam int SYM_W = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1;
  localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(SYM_BITS - 1);

  logic [SYM_W-1:0] sym_cnt;
  logic             at_end;

  assign at_end   = (k == tot);
  assign accept   = bit_tick & start & ~busy;
  assign fin      = bit_tick & busy & at_end;
  assign step     = bit_tick & busy & ~at_end;
  assign sym_zero = (sym_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      k       <= '0;
      sym_cnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      k       <= '0;
      sym_cnt <= '0;
    end else if (fin) begin
      busy    <= 1'b0;
    end else if (step) begin
      k       <= k + 1'b1;
      sym_cnt <= (sym_cnt == SYM_LAST) ? '0 : sym_cnt + 1'b1;
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start && bit_tick));
endmodule

// File: rtl/bts_decode.sv
module bts_decode
  import bts_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_tick,
  input  logic  step,
  input  logic  fin,
  input  bcnt_t k,
  input  bnd_t  bnd,
  input  logic  sym_zero,
  output logic  dfe_on,
  output logic  rse_on,
  output logic  scr_on,
  output logic  dout_en,
  output logic  sym_strobe
);
  bcnt_t k1;
  assign k1 = k + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || fin) begin
      dfe_on     <= 1'b0;
      rse_on     <= 1'b0;
      scr_on     <= 1'b0;
      dout_en    <= 1'b0;
      sym_strobe <= 1'b0;
    end else begin
      sym_strobe <= step & sym_zero;
      if (step) begin
        dfe_on  <= (k >= bnd.pre_s) && (k < bnd.dat_e);
        rse_on  <= (k >= bnd.dat_s) && (k1 < bnd.dat_e);
        scr_on  <= (k >= bnd.dat_s) && (k < bnd.dat_e);
        dout_en <= (k >= bnd.de_s) && (k < bnd.par_e);
      end
    end
  end

  // R8
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> $stable({dfe_on, rse_on, scr_on, dout_en}));
  // R4
  rse_in_scr_chk: assert property (@(posedge clk) disable iff (rst)
    rse_on |-> scr_on);
  // R9
  strobe_short_chk: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |=> !sym_strobe || $past(bit_tick));
endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int T_W      = 4,
  parameter int SYM_BITS = 2,
  parameter int DE_DLY   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             start,
  input  logic [LEN_W-1:0] guard_len,
  input  logic [LEN_W-1:0] pre_len,
  input  logic [LEN_W-1:0] data_len,
  input  logic [LEN_W-1:0] tail_len,
  input  logic [T_W-1:0]   par_words,
  input  logic             par_on,
  output logic             dfe_on,
  output logic             rse_on,
  output logic             scr_on,
  output logic             dout_en,
  output logic             sym_strobe,
  output logic             busy
);
  initial assert (LEN_W + 3 <= CNT_W && T_W + 5 <= CNT_W)
    else $error("bts_seq: bit index too narrow for lengths");

  bnd_t  bnd;
  bcnt_t k;
  logic  accept, step, fin, sym_zero;

  bts_bound #(.LEN_W(LEN_W), .T_W(T_W), .DE_DLY(DE_DLY)) u_bound (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy),
    .guard_len(guard_len), .pre_len(pre_len), .data_len(data_len),
    .tail_len(tail_len), .par_words(par_words), .par_on(par_on), .bnd(bnd)
  );

  bts_cnt #(.SYM_BITS(SYM_BITS)) u_cnt (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start), .tot(bnd.tot),
    .busy(busy), .k(k), .accept(accept), .step(step), .fin(fin),
    .sym_zero(sym_zero)
  );

  bts_decode u_dec (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .step(step), .fin(fin),
    .k(k), .bnd(bnd), .sym_zero(sym_zero), .dfe_on(dfe_on), .rse_on(rse_on),
    .scr_on(scr_on), .dout_en(dout_en), .sym_strobe(sym_strobe)
  );

  // R3
  dfe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (dfe_on || dout_en || sym_strobe) |-> busy);
endmodule

// File: tb/bts_seq_tb_top.sv
module bts_seq_tb_top;
  localparam int SYMB = 2;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, start = 1'b0;
  logic [7:0] g_i = '0, p_i = '0, d_i = '0, h_i = '0;
  logic [3:0] t_i = '0;
  logic pe_i = 1'b0;
  logic dfe, rse, scr, den, sym, busy;

  bts_seq dut_i (
    .clk(clk), .rst(rst), .bit_tick(tick), .start(start), .guard_len(g_i),
    .pre_len(p_i), .data_len(d_i), .tail_len(h_i), .par_words(t_i),
    .par_on(pe_i), .dfe_on(dfe), .rse_on(rse), .scr_on(scr), .dout_en(den),
    .sym_strobe(sym), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference model
  int m_k, mG, mP, mD, mQ, mH, mpe;
  bit m_busy, e_dfe, e_rse, e_scr, e_den, e_sym;
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_k <= 0; e_dfe <= 0; e_rse <= 0; e_scr <= 0;
      e_den <= 0; e_sym <= 0;
    end else begin
      e_sym <= 0;
      if (tick) begin
        if (!m_busy) begin
          if (start) begin
            m_busy <= 1; m_k <= 0;
            mG <= g_i; mP <= p_i; mD <= d_i; mH <= h_i;
            mpe <= pe_i; mQ <= pe_i ? 16 * t_i : 0;
          end
        end else if (m_k == mG + mP + mD + mQ + mH) begin
          m_busy <= 0; e_dfe <= 0; e_rse <= 0; e_scr <= 0; e_den <= 0;
        end else begin
          e_dfe <= (m_k >= mG) && (m_k < mG + mP + mD);
          e_rse <= (m_k >= mG + mP) && (m_k < mG + mP + mD - 1);
          e_scr <= (m_k >= mG + mP) && (m_k < mG + mP + mD);
          e_den <= (m_k >= mG + (mpe ? 8 : 0)) && (m_k < mG + mP + mD + mQ);
          e_sym <= (m_k % SYMB) == 0;
          m_k   <= m_k + 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // tick pattern with gaps of 2 and 3 master clocks
  int tc = 0;
  always @(negedge clk) begin
    if (rst) tick = 0;
    else begin
      tc++;
      tick = (tc % 5 == 0) || (tc % 5 == 2);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R10 busy", busy, m_busy);
      chk("R3/R8 dfe_on", dfe, e_dfe);
      chk("R4/R8 rse_on", rse, e_rse);
      chk("R5/R8 scr_on", scr, e_scr);
      chk("R6/R7 dout_en", den, e_den);
      chk("R9 sym_strobe", sym, e_sym);
    end
  end

  task automatic burst(int g, int p, int d, int t, int h, bit pe, bit hold);
    @(negedge clk);
    g_i = g[7:0]; p_i = p[7:0]; d_i = d[7:0]; h_i = h[7:0];
    t_i = t[3:0]; pe_i = pe; start = 1;
    while (!busy) @(negedge clk);
    // R10: disturb configuration while busy
    g_i = 8'd1; p_i = 8'd3; d_i = 8'd5; h_i = 8'd2; t_i = 4'd2; pe_i = ~pe;
    if (!hold) start = 0;
    while (busy) @(negedge clk);
    if (hold) begin
      // start held across the final tick: refused there, taken next tick
      chk("R10 refused at end tick", busy, 1'b0);
      while (!busy) @(negedge clk);
      start = 0;
      while (busy) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk("R1 busy", busy, 0); chk("R1 dfe_on", dfe, 0); chk("R1 rse_on", rse, 0);
    chk("R1 scr_on", scr, 0); chk("R1 dout_en", den, 0); chk("R1 sym", sym, 0);
    rst = 0;
    repeat (6) @(negedge clk);
    chk("R1 idle busy", busy, 0);
    burst(4, 6, 10, 0, 3, 0, 0);   // R2 R3 R4 R5 R6 plain burst
    burst(0, 3, 2, 0, 0, 0, 0);    // minimal guards, two user bits
    burst(2, 5, 7, 1, 3, 1, 0);    // R7 parity, 16 extra bits
    burst(2, 8, 6, 1, 2, 1, 0);    // R7 delayed rise coincides with data start
    burst(3, 4, 9, 0, 2, 1, 1);    // R10 start held through burst end
    burst(1, 2, 1, 2, 1, 1, 0);    // one user bit, T=2
    repeat (10) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule